// File: doc/BRIEF.md
# Open-Page Multiplexed-Address DRAM Controller

This block sits between a simple request port and a small behavioural DRAM core. The core holds a grid of multi-bit cells (rows by columns) and one row-wide buffer. A requester hands over a flat cell index, a direction and a write word using a valid/ready handshake. The controller splits the index into a row and a column. It then drives one narrow shared address bus in two phases. A row strobe loads a whole row into the buffer. A column strobe then reads or writes one cell of that buffered row.

The row stays open after an access. A later request to the same row therefore costs only a column strobe. A request to a different row first issues a precharge, which writes the buffer back into the grid, and then a new row strobe. Writes change only the buffer until the row is closed. A refresh timer raises a request every `REFRESH_CYCLES` clock cycles. The controller waits until any access in progress has finished. It then closes the open row if there is one, activates the next row in the refresh sequence and precharges it. A pending refresh is served before any waiting request.

The state machine has seven states: `ST_IDLE`, `ST_PRECHARGE`, `ST_ROW_OPEN`, `ST_COL_ACCESS`, `ST_REF_CLOSE`, `ST_REF_ROW` and `ST_REF_DONE`. Its transitions are:
- `ST_IDLE` goes to `ST_REF_CLOSE` when a refresh is pending and a row is open.
- `ST_IDLE` goes to `ST_REF_ROW` when a refresh is pending and no row is open.
- `ST_IDLE` goes to `ST_COL_ACCESS` when a request is accepted for the open row (hit).
- `ST_IDLE` goes to `ST_PRECHARGE` when a request is accepted for a different row.
- `ST_IDLE` goes to `ST_ROW_OPEN` when a request is accepted and no row is open.
- `ST_PRECHARGE` goes to `ST_ROW_OPEN`.
- `ST_ROW_OPEN` goes to `ST_COL_ACCESS`.
- `ST_COL_ACCESS` goes to `ST_IDLE`.
- `ST_REF_CLOSE` goes to `ST_REF_ROW`.
- `ST_REF_ROW` goes to `ST_REF_DONE`.
- `ST_REF_DONE` goes to `ST_IDLE`.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rvalid`, `row_strobe`, `col_strobe` and `pre_strobe` are all 0.
- R2: A flat index i selects row i / COLS and column i % COLS. During a row strobe `dram_addr` carries the row number, and during a column strobe it carries the column number.
- R3: A read to a closed bank issues exactly one row strobe followed by one column strobe. The stored word then appears on `rdata` with `rvalid` high for exactly one cycle, one cycle after the column strobe.
- R4: A request to the row that is already open issues a column strobe and no row strobe.
- R5: A request to a row other than the open one issues one precharge and then one row strobe carrying the new row number.
- R6: A written word is returned by any later read of the same index, including after the row has been closed by a row change.
- R7: When the controller is idle, refresh sequences start exactly `REFRESH_CYCLES` cycles apart. The refresh row strobes visit rows 0, 1, …, ROWS-1 in ascending order and wrap back to 0.
- R8: A refresh that falls due during an access starts only after that access completes. No column strobe occurs while `refresh_active` is high. `req_ready` is low while a refresh is pending or running. Refreshes keep happening under continuous traffic.
- R9: A refresh writes back and closes any open row without losing data. The next access to that row therefore needs a row strobe but no precharge.
- R10: At most one of `row_strobe`, `col_strobe` and `pre_strobe` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | $clog2(ROWS*COLS) | Flat cell index |
| req_wdata | input | DW | Write word |
| rvalid | output | 1 | One-cycle pulse: `rdata` holds the read result |
| rdata | output | DW | Read word |
| dram_addr | output | max(row bits, col bits) | Multiplexed row/column address bus |
| row_strobe | output | 1 | Row activate command |
| col_strobe | output | 1 | Column read/write command |
| pre_strobe | output | 1 | Precharge (row write-back) command |
| refresh_active | output | 1 | A refresh sequence is running |

## Verification
The bench aims at the page policy. It counts row strobes and precharges for each request: a hit must cost none, and a row change must cost exactly one of each. A design that ignored the open row would show extra row strobes, and one that skipped the write-back would return stale words after a row change. It also checks refresh while a stream of back-to-back requests is running. A controller that let a refresh cut into an access would show a column strobe inside a refresh. One that gave requests priority would starve refresh and show too few refresh starts. Finally, it reads back a row that a refresh has closed. A design that lost buffered writes or left the row marked open would return wrong data or skip the needed row strobe.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECHARGE,
        ST_ROW_OPEN,
        ST_COL_ACCESS,
        ST_REF_CLOSE,
        ST_REF_ROW,
        ST_REF_DONE
    } ctrl_state_t;
endpackage

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
    parameter int INTERVAL = 64,
    parameter int ROWS     = 4,
    localparam int CNTW    = (INTERVAL > 1) ? $clog2(INTERVAL) : 1,
    localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    output logic          pending,
    output logic [RW-1:0] row
);
    logic [CNTW-1:0] cnt;
    logic            tick;

    assign tick = (cnt == CNTW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            pending <= 1'b0;
            row     <= '0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick)
                pending <= 1'b1;
            else if (done)
                pending <= 1'b0;
            if (done)
                row <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
        end
    end

    // R8: a refresh request stays pending until it has been served
    p_pending_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !done) |=> pending);
endmodule

// File: rtl/fpm_cell_array.sv
module fpm_cell_array #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int DW   = 8,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int AW  = (RW > CW) ? RW : CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic          pre,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] grid   [ROWS][COLS];
    logic [DW-1:0] rowbuf [COLS];
    logic [RW-1:0] buf_row;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++)
                    grid[r][c] <= '0;
            for (int c = 0; c < COLS; c++)
                rowbuf[c] <= '0;
            buf_row <= '0;
            rdata   <= '0;
        end else begin
            if (act) begin
                rowbuf  <= grid[addr[RW-1:0]];
                buf_row <= addr[RW-1:0];
            end
            if (pre)
                grid[buf_row] <= rowbuf;
            if (rd)
                rdata <= rowbuf[addr[CW-1:0]];
            if (wr)
                rowbuf[addr[CW-1:0]] <= wdata;
        end
    end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ROWS           = 4,
    parameter int COLS           = 4,
    parameter int DW             = 8,
    parameter int REFRESH_CYCLES = 64,
    localparam int RW            = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW            = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int AW            = (RW > CW) ? RW : CW,
    localparam int IW            = $clog2(ROWS * COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [IW-1:0] req_index,
    input  logic [DW-1:0] req_wdata,
    output logic          rvalid,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] dram_addr,
    output logic          row_strobe,
    output logic          col_strobe,
    output logic          pre_strobe,
    output logic          refresh_active
);
    ctrl_state_t   state, state_nx;
    logic [RW-1:0] in_row, req_row_q, open_row, ref_row;
    logic [CW-1:0] in_col, req_col_q;
    logic [DW-1:0] req_wdata_q;
    logic          req_wr_q, row_open, ref_pending, ref_done, accept, hit;

    assign in_row    = RW'(req_index / IW'(COLS));
    assign in_col    = CW'(req_index % IW'(COLS));
    assign req_ready = (state == ST_IDLE) && !ref_pending;
    assign accept    = req_valid && req_ready;
    assign hit       = row_open && (in_row == open_row);
    assign ref_done  = (state == ST_REF_DONE);

    fpm_refresh_timer #(.INTERVAL(REFRESH_CYCLES), .ROWS(ROWS)) u_timer (
        .clk(clk), .rst_n(rst_n), .done(ref_done),
        .pending(ref_pending), .row(ref_row)
    );

    fpm_cell_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_cells (
        .clk(clk), .rst_n(rst_n),
        .act(row_strobe), .pre(pre_strobe),
        .rd(col_strobe && !req_wr_q), .wr(col_strobe && req_wr_q),
        .addr(dram_addr), .wdata(req_wdata_q), .rdata(rdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ref_pending)
                    state_nx = row_open ? ST_REF_CLOSE : ST_REF_ROW;
                else if (req_valid)
                    state_nx = !row_open ? ST_ROW_OPEN :
                               (hit ? ST_COL_ACCESS : ST_PRECHARGE);
            end
            ST_PRECHARGE:  state_nx = ST_ROW_OPEN;
            ST_ROW_OPEN:   state_nx = ST_COL_ACCESS;
            ST_COL_ACCESS: state_nx = ST_IDLE;
            ST_REF_CLOSE:  state_nx = ST_REF_ROW;
            ST_REF_ROW:    state_nx = ST_REF_DONE;
            ST_REF_DONE:   state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // command outputs
    always_comb begin
        row_strobe     = 1'b0;
        col_strobe     = 1'b0;
        pre_strobe     = 1'b0;
        refresh_active = 1'b0;
        dram_addr      = '0;
        unique case (state)
            ST_IDLE: ;
            ST_PRECHARGE: begin
                pre_strobe = 1'b1;
                dram_addr  = AW'(open_row);
            end
            ST_ROW_OPEN: begin
                row_strobe = 1'b1;
                dram_addr  = AW'(req_row_q);
            end
            ST_COL_ACCESS: begin
                col_strobe = 1'b1;
                dram_addr  = AW'(req_col_q);
            end
            ST_REF_CLOSE: begin
                pre_strobe     = 1'b1;
                refresh_active = 1'b1;
                dram_addr      = AW'(open_row);
            end
            ST_REF_ROW: begin
                row_strobe     = 1'b1;
                refresh_active = 1'b1;
                dram_addr      = AW'(ref_row);
            end
            ST_REF_DONE: begin
                pre_strobe     = 1'b1;
                refresh_active = 1'b1;
                dram_addr      = AW'(ref_row);
            end
            default: ;
        endcase
    end

    // request latch, open-row tracking, read-valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_row_q   <= '0;
            req_col_q   <= '0;
            req_wdata_q <= '0;
            req_wr_q    <= 1'b0;
            row_open    <= 1'b0;
            open_row    <= '0;
            rvalid      <= 1'b0;
        end else begin
            if (accept) begin
                req_row_q   <= in_row;
                req_col_q   <= in_col;
                req_wdata_q <= req_wdata;
                req_wr_q    <= req_write;
            end
            if (state == ST_ROW_OPEN) begin
                row_open <= 1'b1;
                open_row <= req_row_q;
            end else if (state == ST_PRECHARGE || state == ST_REF_CLOSE) begin
                row_open <= 1'b0;
            end
            rvalid <= (state == ST_COL_ACCESS) && !req_wr_q;
        end
    end

    p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({row_strobe, col_strobe, pre_strobe}));
    p_rvalid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);
    p_rvalid_after_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(col_strobe));
    p_col_needs_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        col_strobe |-> row_open);
    p_row_after_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRECHARGE) |=> (row_strobe && !refresh_active));
    p_no_col_in_refresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_active |-> (!col_strobe && !req_ready));
    p_refresh_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ref_pending) |=> refresh_active);
endmodule

// File: tb/test_fpm_dram_ctrl.sv
module test_fpm_dram_ctrl;
    localparam int ROWS = 4, COLS = 4, DW = 8, NREF = 200;
    localparam int IW = 4, AW = 2, CELLS = ROWS * COLS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [IW-1:0] req_index = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rvalid, row_strobe, col_strobe, pre_strobe, refresh_active;
    logic [DW-1:0] rdata;
    logic [AW-1:0] dram_addr;

    always #10 clk = ~clk;

    fpm_dram_ctrl #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .REFRESH_CYCLES(NREF)) i_fpm_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_index(req_index), .req_wdata(req_wdata),
        .rvalid(rvalid), .rdata(rdata), .dram_addr(dram_addr),
        .row_strobe(row_strobe), .col_strobe(col_strobe), .pre_strobe(pre_strobe),
        .refresh_active(refresh_active)
    );

    int checks = 0, fails = 0, cyc = 0;
    int n_row = 0, n_pre = 0, n_ref_rise = 0, n_overlap = 0, n_ready_bad = 0;
    int ref_order_err = 0, exp_ref_row = 0, n_ref_rows = 0;
    logic [AW-1:0] last_row_addr = '0, last_col_addr = '0;
    logic ref_prev = 1'b0;
    logic [DW-1:0] exp_mem [CELLS];

    always @(posedge clk) begin
        cyc++;
        if (rst_n) begin
            if (row_strobe && !refresh_active) begin n_row++; last_row_addr = dram_addr; end
            if (pre_strobe && !refresh_active) n_pre++;
            if (col_strobe) last_col_addr = dram_addr;
            if (col_strobe && refresh_active) n_overlap++;
            if (refresh_active && !ref_prev) n_ref_rise++;
            if (row_strobe && refresh_active) begin
                if (int'(dram_addr) != exp_ref_row) ref_order_err++;
                exp_ref_row = (exp_ref_row + 1) % ROWS;
                n_ref_rows++;
            end
            ref_prev = refresh_active;
        end
    end

    always @(negedge clk)
        if (rst_n && refresh_active && req_ready) n_ready_bad++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_req(input bit w, input int idx, input logic [DW-1:0] d,
                          output logic [DW-1:0] rd, output int drow, output int dpre);
        int r0 = n_row, p0 = n_pre, t;
        rd = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_index = IW'(idx); req_wdata = d;
        t = 0;
        while (!req_ready && t < 1000) begin @(negedge clk); t++; end
        @(negedge clk);
        req_valid = 1'b0;
        if (w) exp_mem[idx] = d;
        t = 0;
        if (!w) begin
            while (!rvalid && t < 50) begin @(negedge clk); t++; end
            rd = rdata;
        end else begin
            while (!req_ready && t < 1000) begin @(negedge clk); t++; end
        end
        if (t >= 50 && !w) chk(0, "R3 read timeout", t, 0);
        drow = n_row - r0;
        dpre = n_pre - p0;
    endtask

    task automatic rd_check(input int idx, input string tag, output int drow, output int dpre);
        logic [DW-1:0] v;
        do_req(1'b0, idx, '0, v, drow, dpre);
        chk(v === exp_mem[idx], tag, int'(v), int'(exp_mem[idx]));
    endtask

    task automatic wait_refresh_end();
        int t = 0;
        while (!refresh_active && t < 1000) begin @(negedge clk); t++; end
        while (refresh_active && t < 1000) begin @(negedge clk); t++; end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(rvalid === 1'b0, "R1 rvalid after reset", int'(rvalid), 0);
        chk({row_strobe, col_strobe, pre_strobe} === 3'b000, "R1 strobes after reset",
            int'({row_strobe, col_strobe, pre_strobe}), 0);
    endtask

    task automatic t_fill();
        logic [DW-1:0] v;
        int dr, dp, bad = 0;
        for (int i = 0; i < CELLS; i++) do_req(1'b1, i, DW'(i * 37 + 11), v, dr, dp);
        for (int k = 0; k < CELLS; k++) begin
            int idx = (k * 5 + 3) % CELLS;
            do_req(1'b0, idx, '0, v, dr, dp);
            if (v !== exp_mem[idx]) begin
                bad++;
                $display("FAIL R6 idx %0d actual=%0d expected=%0d", idx, v, exp_mem[idx]);
            end
        end
        checks++;
        if (bad != 0) fails++;
    endtask

    task automatic t_page();
        int dr, dp, sum_r = 0;
        wait_refresh_end();
        rd_check(9, "R3 closed-row read data", dr, dp);
        chk(dr == 1, "R3 one row strobe on closed bank", dr, 1);
        chk(last_row_addr == 2, "R2 row address of index 9", int'(last_row_addr), 2);
        chk(last_col_addr == 1, "R2 column address of index 9", int'(last_col_addr), 1);
        @(negedge clk);
        chk(rvalid === 1'b0, "R3 rvalid single cycle", int'(rvalid), 0);
        rd_check(10, "R4 hit data 10", dr, dp); sum_r += dr + dp;
        rd_check(11, "R4 hit data 11", dr, dp); sum_r += dr + dp;
        rd_check(8, "R4 hit data 8", dr, dp);   sum_r += dr + dp;
        chk(sum_r == 0, "R4 no row strobe or precharge on hits", sum_r, 0);
        chk(last_col_addr == 0, "R2 column address of index 8", int'(last_col_addr), 0);
        rd_check(13, "R5 row change data", dr, dp);
        chk(dp == 1, "R5 one precharge on row change", dp, 1);
        chk(dr == 1, "R5 one row strobe on row change", dr, 1);
        chk(last_row_addr == 3, "R5 new row address", int'(last_row_addr), 3);
    endtask

    task automatic t_write_back();
        logic [DW-1:0] v;
        int dr, dp;
        wait_refresh_end();
        do_req(1'b1, 4, 8'h5A, v, dr, dp);
        do_req(1'b1, 6, 8'hC3, v, dr, dp);
        rd_check(0, "R6 other row read", dr, dp);
        rd_check(4, "R6 write survives row change (4)", dr, dp);
        rd_check(6, "R6 write survives row change (6)", dr, dp);
    endtask

    task automatic t_refresh_close();
        logic [DW-1:0] v;
        int dr, dp;
        wait_refresh_end();
        do_req(1'b1, 7, 8'h3C, v, dr, dp);
        wait_refresh_end();
        rd_check(7, "R9 buffered write kept across refresh", dr, dp);
        chk(dr == 1, "R9 row strobe after refresh", dr, 1);
        chk(dp == 0, "R9 no precharge after refresh", dp, 0);
    endtask

    task automatic t_interval();
        int c0, c1, t = 0;
        wait_refresh_end();
        while (!refresh_active && t < 1000) begin @(negedge clk); t++; end
        c0 = cyc;
        while (refresh_active && t < 1000) begin @(negedge clk); t++; end
        while (!refresh_active && t < 1000) begin @(negedge clk); t++; end
        c1 = cyc;
        chk(c1 - c0 == NREF, "R7 refresh spacing when idle", c1 - c0, NREF);
    endtask

    task automatic t_stream();
        int dr, dp, r0 = n_ref_rise, bad = 0;
        logic [DW-1:0] v;
        for (int i = 0; i < 150; i++) begin
            int idx = 4 + (i % 4);
            do_req(1'b0, idx, '0, v, dr, dp);
            if (v !== exp_mem[idx]) bad++;
        end
        chk(bad == 0, "R8 stream read data", bad, 0);
        chk(n_ref_rise - r0 >= 2, "R8 refresh under traffic", n_ref_rise - r0, 2);
        chk(n_overlap == 0, "R8 column strobe during refresh", n_overlap, 0);
        chk(n_ready_bad == 0, "R8 ready during refresh", n_ready_bad, 0);
    endtask

    task automatic t_order();
        chk(ref_order_err == 0, "R7 refresh row order", ref_order_err, 0);
        chk(n_ref_rows >= ROWS + 1, "R7 refresh wraps rows", n_ref_rows, ROWS + 1);
    endtask

    initial begin
        for (int i = 0; i < CELLS; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_page();
        t_write_back();
        t_refresh_close();
        t_interval();
        t_stream();
        t_order();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule